// File: doc/BRIEF.md
# Mod-3 Residue Checker with Error Location

This block checks words of a separable residue code. A word is six bits wide. The upper four bits carry an unsigned information value, with the most significant bit in bit 5. The lower two bits carry a check value that should equal the information value modulo 3. For each word presented on a strobe, the block works out the residue again and raises an error flag when the check field does not match it.

The block then asks, for every bit of the word, whether inverting that one bit would produce a consistent word. Each bit that passes this test sets its bit in a candidate mask, and the block also reports how many candidates there are. When exactly one bit qualifies, the block also outputs the word with that bit inverted, which is the corrected word under a single-error assumption. A mask with more than one bit set means the error position is ambiguous. All results come from registers and appear one clock after the strobe.

The mod-3 reduction uses no divider. Bit k of the value adds 1 when k is even and 2 when k is odd, and the running sum is folded back into the range 0 to 2. A parameter can swap in a plain modulo operator as a reference variant.

Top module: `res3_locator`

## Requirements
- R1: In the result of a strobe, `err` is 1 exactly when `in_word[1:0]` differs from `in_word[5:2]` mod 3. Example: information 0101 with check 10 gives `err`=0. Information 0111 with check 10 gives `err`=1.
- R2: `cand_mask[i]` is 1 exactly when the word with only bit i inverted has a check field equal to its own information field mod 3. For bits 1:0 this means the flipped check field is compared with the unchanged information residue. Example: 0110 with check 01 gives mask 6'b001101.
- R3: A check field of 11 never counts as consistent. Any word with check 11 has `err`=1, and a check-bit flip that yields 11 never sets its mask bit.
- R4: `cand_count` equals the number of ones in `cand_mask`.
- R5: For a consistent word, `cand_mask` is 0, `cand_count` is 0 and `corr_word` equals the input word.
- R6: When `cand_count` is 1, `corr_word` is the input word with the single candidate bit inverted. Example: 011110 is corrected to 010110. For any other count, `corr_word` equals the input word.
- R7: `out_valid` is 1 in exactly the cycle after an `in_valid` strobe. Back-to-back strobes give back-to-back results.
- R8: A synchronous active-high `rst` forces `out_valid` to 0 on the next edge, even when `in_valid` is high in the same cycle.
- R9: The mod-3 reduction matches arithmetic modulo for all 64 possible words, as seen through `err`, `cand_mask` and `corr_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: a word to check is on `in_word` |
| in_word | input | 6 | Information bits [5:2], check bits [1:0] |
| out_valid | output | 1 | The result outputs hold a new result |
| err | output | 1 | Residue mismatch |
| cand_mask | output | 6 | Bits whose single inversion makes the word consistent |
| cand_count | output | 3 | Number of set bits in `cand_mask` |
| corr_word | output | 6 | Corrected word when `cand_count` is 1, otherwise the input word |

## Verification
Two events can land in the same cycle: a strobe that captures a new result, and a synchronous reset that clears `out_valid`. The bench raises `rst` and `in_valid` together with a faulty word on the input. At the following sample it requires `out_valid` to be low, because reset must win. It then issues a clean strobe and confirms that results resume one cycle later. Back-to-back strobes also run through the whole word space, so that the result of each word can be judged against the next strobe arriving in the same cycle.

// File: rtl/res3_pkg.sv
package res3_pkg;

   typedef logic [1:0] res_t;

   localparam int RES3_IMPL_FOLD = 0;
   localparam int RES3_IMPL_REF  = 1;

   // residue by position weights: 2^k mod 3 alternates 1, 2, 1, 2, ...
   function automatic res_t res3_fold(input logic [31:0] v);
      logic [2:0] acc;
      acc = 3'd0;
      for (int k = 0; k < 32; k++) begin
         if (v[k]) begin
            acc = acc + (((k % 2) == 0) ? 3'd1 : 3'd2);
            if (acc >= 3'd3) acc = acc - 3'd3;
         end
      end
      return acc[1:0];
   endfunction

   function automatic res_t res3_ref(input logic [31:0] v);
      logic [31:0] m;
      m = v % 32'd3;
      return m[1:0];
   endfunction

endpackage

// File: rtl/res3_calc.sv
module res3_calc
   import res3_pkg::*;
#(
   parameter int W    = 4,
   parameter int IMPL = RES3_IMPL_FOLD
) (
   input  logic [W-1:0] val,
   output res_t         res
);
   initial begin
      if (W < 1 || W > 32) $error("res3_calc: W must lie in 1..32");
      if (IMPL != RES3_IMPL_FOLD && IMPL != RES3_IMPL_REF)
         $error("res3_calc: unknown IMPL");
   end

   logic [31:0] val_ext;
   assign val_ext = 32'(val);

   generate
      if (IMPL == RES3_IMPL_REF) begin : g_ref
         assign res = res3_ref(val_ext);
      end else begin : g_fold
         assign res = res3_fold(val_ext);
      end
   endgenerate
endmodule

// File: rtl/res3_flip_probe.sv
module res3_flip_probe
   import res3_pkg::*;
#(
   parameter int INFO_W = 4,
   parameter int POS    = 0,
   parameter int IMPL   = RES3_IMPL_FOLD
) (
   input  logic [INFO_W+1:0] word,
   output logic              hit
);
   localparam int WORD_W = INFO_W + 2;

   initial begin
      if (POS < 0 || POS >= WORD_W) $error("res3_flip_probe: POS out of range");
   end

   logic [WORD_W-1:0] flipped;
   res_t              info_res;

   assign flipped = word ^ (WORD_W'(1) << POS);

   res3_calc #(.W(INFO_W), .IMPL(IMPL)) calc_i (
      .val (flipped[WORD_W-1:2]),
      .res (info_res)
   );

   // a flipped check field of 11 can never equal a residue
   assign hit = (flipped[1:0] == info_res);
endmodule

// File: rtl/res3_popcount.sv
module res3_popcount #(
   parameter int N  = 6,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  bits,
   output logic [CW-1:0] count
);
   initial begin
      if (CW < $clog2(N + 1)) $error("res3_popcount: CW too narrow");
   end

   always_comb begin
      count = '0;
      for (int i = 0; i < N; i++) count = count + CW'(bits[i]);
   end
endmodule

// File: rtl/res3_locator.sv
module res3_locator
   import res3_pkg::*;
#(
   parameter int INFO_W = 4,
   parameter int IMPL   = RES3_IMPL_FOLD,
   localparam int WORD_W = INFO_W + 2,
   localparam int CNT_W  = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   output logic              err,
   output logic [WORD_W-1:0] cand_mask,
   output logic [CNT_W-1:0]  cand_count,
   output logic [WORD_W-1:0] corr_word
);
   initial begin
      if (INFO_W < 2 || INFO_W > 30) $error("res3_locator: INFO_W must lie in 2..30");
   end

   res_t              in_res;
   logic              err_d;
   logic [WORD_W-1:0] hit_d;
   logic [CNT_W-1:0]  cnt_d;
   logic [WORD_W-1:0] corr_d;

   res3_calc #(.W(INFO_W), .IMPL(IMPL)) base_i (
      .val (in_word[WORD_W-1:2]),
      .res (in_res)
   );

   assign err_d = (in_word[1:0] != in_res);

   generate
      for (genvar p = 0; p < WORD_W; p++) begin : g_probe
         res3_flip_probe #(.INFO_W(INFO_W), .POS(p), .IMPL(IMPL)) probe_i (
            .word (in_word),
            .hit  (hit_d[p])
         );
      end
   endgenerate

   res3_popcount #(.N(WORD_W), .CW(CNT_W)) pop_i (
      .bits  (hit_d),
      .count (cnt_d)
   );

   assign corr_d = (cnt_d == CNT_W'(1)) ? (in_word ^ hit_d) : in_word;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         err        <= 1'b0;
         cand_mask  <= '0;
         cand_count <= '0;
         corr_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            err        <= err_d;
            cand_mask  <= hit_d;
            cand_count <= cnt_d;
            corr_word  <= corr_d;
         end
      end
   end
endmodule

// File: rtl/res3_locator_chk.sv
module res3_locator_chk #(
   parameter int INFO_W = 4,
   localparam int WORD_W = INFO_W + 2,
   localparam int CNT_W  = $clog2(WORD_W + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [WORD_W-1:0] in_word,
   input logic              out_valid,
   input logic              err,
   input logic [WORD_W-1:0] cand_mask,
   input logic [CNT_W-1:0]  cand_count,
   input logic [WORD_W-1:0] corr_word
);
   logic rst_seen = 1'b0;
   always_ff @(posedge clk) rst_seen <= rst;

   // R8
   always_ff @(posedge clk) begin
      if (rst_seen) reset_clears_chk: assert (!out_valid);
   end

   // R7
   strobe_latency_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R7
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R4
   count_matches_mask_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($countones(cand_mask) == int'(cand_count)));

   // R5
   clean_word_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !err) |-> (cand_mask == '0 && corr_word == $past(in_word)));

   // R3
   illegal_check_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(in_word[1:0]) == 2'b11) |-> err);

   // R6
   single_fix_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && cand_count == CNT_W'(1)) |->
         ((corr_word ^ $past(in_word)) == cand_mask));
endmodule

bind res3_locator res3_locator_chk #(.INFO_W(INFO_W)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_word    (in_word),
   .out_valid  (out_valid),
   .err        (err),
   .cand_mask  (cand_mask),
   .cand_count (cand_count),
   .corr_word  (corr_word)
);

// File: tb/res3_locator_tb_top.sv
module res3_locator_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [5:0] in_word = '0;
   logic       out_valid;
   logic       err;
   logic [5:0] cand_mask;
   logic [2:0] cand_count;
   logic [5:0] corr_word;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   res3_locator dut_i (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_word    (in_word),
      .out_valid  (out_valid),
      .err        (err),
      .cand_mask  (cand_mask),
      .cand_count (cand_count),
      .corr_word  (corr_word)
   );

   function automatic bit ref_err(input logic [5:0] w);
      int v;
      v = int'(w[5:2]);
      return int'(w[1:0]) != (v % 3);
   endfunction

   function automatic logic [5:0] ref_mask(input logic [5:0] w);
      logic [5:0] m;
      m = '0;
      for (int i = 0; i < 6; i++) m[i] = !ref_err(w ^ (6'b1 << i));
      return m;
   endfunction

   function automatic int ref_count(input logic [5:0] m);
      int c;
      c = 0;
      for (int i = 0; i < 6; i++) c += int'(m[i]);
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // drives a word at the falling edge, judges the result one edge later
   task automatic apply(input logic [5:0] w);
      logic [5:0] m;
      int         c;
      in_valid = 1'b1;
      in_word  = w;
      @(negedge clk);
      m = ref_mask(w);
      c = ref_count(m);
      check(out_valid == 1'b1, "R7 out_valid", int'(out_valid), 1);
      check(err == ref_err(w), "R1/R9 err", int'(err), int'(ref_err(w)));
      check(cand_mask == m, "R2/R3 cand_mask", int'(cand_mask), int'(m));
      check(int'(cand_count) == c, "R4 cand_count", int'(cand_count), c);
      if (c == 1)
         check(corr_word == (w ^ m), "R6 corr_word", int'(corr_word), int'(w ^ m));
      else
         check(corr_word == w, "R5/R6 corr_word", int'(corr_word), int'(w));
   endtask

   initial begin
      void'($urandom(32'h0000_5e3d));
      @(negedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R8 reset state", int'(out_valid), 0);
      rst = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R7 idle", int'(out_valid), 0);

      // directed corner cases
      apply(6'b010110);
      check(err == 1'b0 && cand_mask == 6'b0, "R5 clean 0101/10", int'(cand_mask), 0);
      apply(6'b011110);
      check(corr_word == 6'b010110, "R6 fix 0111/10", int'(corr_word), 'h16);
      apply(6'b011001);
      check(cand_mask == 6'b001101, "R2 three candidates", int'(cand_mask), 'h0d);
      apply(6'b000011);
      check(err == 1'b1, "R3 check 11", int'(err), 1);
      apply(6'b111100);
      in_valid = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R7 single pulse", int'(out_valid), 0);

      // exhaustive, back to back
      for (int w = 0; w < 64; w++) apply(6'(w));
      in_valid = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R7 stream end", int'(out_valid), 0);

      // reset and strobe together
      rst      = 1'b1;
      in_valid = 1'b1;
      in_word  = 6'b011110;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 reset beats strobe", int'(out_valid), 0);
      rst      = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 after reset", int'(out_valid), 0);

      // random words with random gaps
      for (int k = 0; k < 300; k++) begin
         apply(6'($urandom));
         if (($urandom % 4) == 0) begin
            in_valid = 1'b0;
            @(negedge clk);
            check(out_valid == 1'b0, "R7 gap", int'(out_valid), 0);
         end
      end
      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      for (int t = 0; t < 20000; t++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
      end
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule